// File: doc/BRIEF.md
# Reset Supervisor with Push-Button Debounce

This block generates the system reset for a board whose reset line is an open-drain net. The block and a push-button switch share that net. The block reads the net level on `line_i` and pulls the net low through `pull_low_o`. Three things can start a reset cycle:

- a digital power-fail indication;
- a press of the button, seen as the net going low;
- a one-cycle request from an external timeout source.

One hold timer sets the length of every reset pulse. The timer counts ticks, and a prescaler derives each tick from the clock. Both lengths are parameters, so a simulation can run with scaled-down times.

When the button pulls the net low, the block first pulls the net low itself for one hold period. This acts as a debounce. The block then lets go of the net and waits until the button is released. After the release it pulls the net low for one more full hold period.

A power-fail always has priority. It cancels any button phase in progress. Power-up release can also be delayed by an "oscillator start-up pending" input: the hold count starts only after that input falls. `rst_active_o` reports that a reset cycle is in progress. This includes the phase in which only the button holds the net low.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst_n` is low, `pull_low_o` and `rst_active_o` are both 1. After `rst_n` is released, the pull stays on for one hold period of HOLD_TICKS*TICK_DIV cycles (tolerance +2 cycles).
- R2: From the clock edge after `pwr_fail_i` is sampled 1, `pull_low_o` is 1, and it stays 1 for as long as `pwr_fail_i` stays 1.
- R3: Once `pwr_fail_i` returns to 0, `pull_low_o` stays 1 for one more hold period of HOLD_TICKS*TICK_DIV cycles (tolerance +2). No pull pulse of any kind ends sooner than HOLD_TICKS*TICK_DIV cycles.
- R4: During a power-up hold, the hold count does not start while `osc_wait_i` is 1. It starts once `osc_wait_i` falls, so the pull lasts the wait time plus a full hold period.
- R5: With no cycle in progress, a falling edge of `line_i` (1 = net high) starts a debounce, during which `pull_low_o` is 1 for one hold period.
- R6: After the debounce, `pull_low_o` drops to 0. If the net is still low, the block stays in reset with `rst_active_o` = 1 and `pull_low_o` = 0 until `line_i` reads 1. It then pulls for a further hold period.
- R7: If the button is released during the debounce, the second hold pulse starts within SYNC_STAGES+4 cycles after the debounce ends.
- R8: Net edges caused by the block's own pull are ignored. When a pulse ends, no new cycle starts unless a fresh falling edge or request arrives.
- R9: A one-cycle `ext_req_i` with no cycle in progress starts one hold pulse on the next clock edge. A request that arrives while a cycle is in progress has no effect.
- R10: A power-fail during any button phase cancels that phase. The block goes straight to the power-fail hold, and the button sequence does not resume afterwards.
- R11: `rst_active_o` is 1 whenever `pull_low_o` is 1 and during the release wait. It is 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail_i | input | 1 | Power out of tolerance (1 = fail) |
| osc_wait_i | input | 1 | Oscillator start-up still pending (1 = pending) |
| ext_req_i | input | 1 | Reset request from an external timeout source |
| line_i | input | 1 | Sampled level of the shared reset net (1 = high) |
| pull_low_o | output | 1 | Enables the pull-low driver on the net |
| rst_active_o | output | 1 | A reset cycle is in progress |

## Verification
A wrong state or a wrong timer value shows at the ports as a pull pulse of the wrong length, a missing second pulse, or an extra pulse. The extra pulse would come from the block reacting to its own pull. The pulse lengths are measured at the ports and compared with values worked out from the parameters, so a timer or state error is seen within one hold period. A release wait that is entered wrongly shows as `rst_active_o` disagreeing with `pull_low_o` while the button is still held.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PFAIL = 3'd1,
    ST_PWRUP = 3'd2,
    ST_DEBNC = 3'd3,
    ST_WREL  = 3'd4,
    ST_PULSE = 3'd5
  } rsv_state_e;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  // the net idles high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsv_tick.sv
module rsv_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rsv_hold.sv
module rsv_hold #(
  parameter int TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int TW = $clog2(TICKS + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == TW'(TICKS));
  assign cnt_en = tick_i && !done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
  import rsv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic osc_wait_i,
  input  logic ext_req_i,
  input  logic line_s_i,
  input  logic done_i,
  output logic timer_clr_o,
  output logic pull_low_o,
  output logic rst_active_o
);
  // cycles the synchronised net needs to show the level once the pull is off
  localparam int SETTLE = SYNC_STAGES + 2;
  localparam int SW     = $clog2(SETTLE + 1);

  rsv_state_e    st_q, st_d;
  logic          prev_q;
  logic          fall;
  logic [SW-1:0] settle_q, settle_d;
  logic          settled;

  assign fall    = prev_q && !line_s_i;
  assign settled = (settle_q == SW'(SETTLE));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (fall)           st_d = ST_DEBNC;
        else if (ext_req_i) st_d = ST_PULSE;
      end
      ST_PFAIL: st_d = ST_PWRUP;
      ST_PWRUP: if (done_i && !osc_wait_i) st_d = ST_IDLE;
      ST_DEBNC: if (done_i) st_d = ST_WREL;
      ST_WREL:  if (settled && line_s_i) st_d = ST_PULSE;
      ST_PULSE: if (done_i) st_d = ST_IDLE;
      default:  st_d = ST_PWRUP;
    endcase
    if (pwr_fail_i) st_d = ST_PFAIL;
  end

  always_comb begin
    settle_d = '0;
    if (st_q == ST_WREL) settle_d = settled ? settle_q : settle_q + 1'b1;
  end

  assign timer_clr_o  = (st_d != st_q) || ((st_q == ST_PWRUP) && osc_wait_i);
  assign pull_low_o   = (st_q == ST_PFAIL) || (st_q == ST_PWRUP) ||
                        (st_q == ST_DEBNC) || (st_q == ST_PULSE);
  assign rst_active_o = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_PWRUP;
      prev_q   <= 1'b1;
      settle_q <= '0;
    end else begin
      st_q     <= st_d;
      prev_q   <= line_s_i;
      settle_q <= settle_d;
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int TICK_DIV    = 4,
  parameter int HOLD_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic osc_wait_i,
  input  logic ext_req_i,
  input  logic line_i,
  output logic pull_low_o,
  output logic rst_active_o
);
  logic line_s;
  logic timer_clr;
  logic tick;
  logic done;

  rsv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  rsv_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr), .tick_o(tick)
  );

  rsv_hold #(.TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_i(timer_clr), .tick_i(tick), .done_o(done)
  );

  rsv_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pwr_fail_i(pwr_fail_i), .osc_wait_i(osc_wait_i), .ext_req_i(ext_req_i),
    .line_s_i(line_s), .done_i(done),
    .timer_clr_o(timer_clr), .pull_low_o(pull_low_o), .rst_active_o(rst_active_o)
  );
endmodule

// File: rtl/rsv_chk.sv
module rsv_chk #(
  parameter int TICK_DIV   = 4,
  parameter int HOLD_TICKS = 10
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail_i,
  input logic ext_req_i,
  input logic pull_low_o,
  input logic rst_active_o
);
  localparam int unsigned MIN_HOLD = HOLD_TICKS * TICK_DIV;

  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 0;
    else if (pull_low_o) run_q <= run_q + 1;
    else                 run_q <= 0;
  end

  AST_PF_FORCES_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> pull_low_o); // R2

  AST_PULL_MEANS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low_o |-> rst_active_o); // R11

  AST_EXT_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_active_o && ext_req_i) |=> pull_low_o); // R9

  AST_HOLD_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_low_o) |-> (run_q >= MIN_HOLD)); // R3
endmodule

bind rst_supervisor rsv_chk #(.TICK_DIV(TICK_DIV), .HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail_i), .ext_req_i(ext_req_i),
  .pull_low_o(pull_low_o), .rst_active_o(rst_active_o)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int DIV = 4;
  localparam int HT  = 10;
  localparam int SS  = 2;
  localparam int HD  = HT * DIV;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic osc_wait = 1'b0;
  logic ext_req = 1'b0;
  logic btn = 1'b0;
  logic line;
  logic pull_low;
  logic rst_active;

  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;
  int   run = 0;
  exp_t exq[$];

  always #5 clk = ~clk;

  // open-drain net: low when the block pulls or the button is held
  assign line = !(pull_low || btn);

  rst_supervisor #(.TICK_DIV(DIV), .HOLD_TICKS(HT), .SYNC_STAGES(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail_i(pwr_fail), .osc_wait_i(osc_wait),
    .ext_req_i(ext_req), .line_i(line), .pull_low_o(pull_low),
    .rst_active_o(rst_active)
  );

  // monitor: measures each pull pulse and checks it against the queue
  always @(negedge clk) begin
    if (pull_low === 1'b1) begin
      run = run + 1;
    end else if (run > 0) begin
      total = total + 1;
      if (exq.size() == 0) begin
        bad = bad + 1;
        $display("FAIL R8 unexpected pulse: actual len=%0d expected none", run);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (run < e.lo || run > e.hi) begin
          bad = bad + 1;
          $display("FAIL %s pulse length: actual=%0d expected=%0d..%0d",
                   e.tag, run, e.lo, e.hi);
        end
      end
      run = 0;
    end
  end

  task automatic expect_pulse(input int lo, input int hi, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (rst_active === 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    int t;

    // R1: reset state, then power-up hold
    expect_pulse(HD + 3, HD + 7, "R1");
    tick(3);
    chk(pull_low === 1'b1 && rst_active === 1'b1, "R1 reset outputs",
        int'({pull_low, rst_active}), 3);
    tick(2);
    rst_n = 1'b1;
    wait_idle();
    tick(5);
    chk(rst_active === 1'b0 && pull_low === 1'b0, "R11 idle after power-up",
        int'({pull_low, rst_active}), 0);

    // R2/R3: power-fail then hold
    expect_pulse(20 + HD - 1, 20 + HD + 3, "R3");
    pwr_fail = 1'b1;
    tick(1);
    chk(pull_low === 1'b1, "R2 pull after power-fail", int'(pull_low), 1);
    tick(19);
    chk(pull_low === 1'b1, "R2 pull held during power-fail", int'(pull_low), 1);
    pwr_fail = 1'b0;
    tick(HD - 2);
    chk(pull_low === 1'b1, "R3 pull held after power return", int'(pull_low), 1);
    wait_idle();
    tick(5);

    // R4: oscillator start-up pending extends the hold
    osc_wait = 1'b1;
    expect_pulse(10 + 60 + HD - 1, 10 + 60 + HD + 3, "R4");
    pwr_fail = 1'b1;
    tick(10);
    pwr_fail = 1'b0;
    tick(HD + 10);
    chk(pull_low === 1'b1, "R4 pull held while oscillator pending", int'(pull_low), 1);
    tick(60 - HD - 10);
    osc_wait = 1'b0;
    wait_idle();
    tick(5);

    // R9: external request in idle, a second one ignored mid-cycle
    expect_pulse(HD, HD + 3, "R9");
    ext_req = 1'b1;
    tick(1);
    ext_req = 1'b0;
    chk(pull_low === 1'b1, "R9 pull after request", int'(pull_low), 1);
    tick(10);
    ext_req = 1'b1;
    tick(1);
    ext_req = 1'b0;
    wait_idle();
    tick(20);
    chk(exq.size() == 0, "R9 request during cycle ignored", exq.size(), 0);

    // R5/R6: long press, wait for release
    expect_pulse(HD, HD + 3, "R5");
    expect_pulse(HD, HD + 3, "R6");
    btn = 1'b1;
    tick(HD + 20);
    chk(pull_low === 1'b0 && rst_active === 1'b1, "R6 release wait",
        int'({pull_low, rst_active}), 1);
    tick(20);
    btn = 1'b0;
    wait_idle();
    tick(30);
    chk(exq.size() == 0 && rst_active === 1'b0, "R8 no cycle after own pull",
        exq.size(), 0);

    // R7: short press released during debounce
    expect_pulse(HD, HD + 3, "R5");
    expect_pulse(HD, HD + 3, "R7");
    btn = 1'b1;
    tick(6);
    btn = 1'b0;
    t = 6;
    for (int i = 0; i < 1000; i++) begin
      if (rst_active === 1'b0) break;
      @(negedge clk);
      t = t + 1;
    end
    chk(t <= 2 * HD + SS + 14, "R7 second pulse follows promptly", t, 2 * HD + SS + 14);
    tick(30);
    chk(exq.size() == 0, "R8 no extra cycle after short press", exq.size(), 0);

    // R10: power-fail during the release wait aborts the button sequence
    expect_pulse(HD, HD + 3, "R5");
    expect_pulse(10 + HD - 1, 10 + HD + 3, "R10");
    btn = 1'b1;
    tick(HD + 15);
    chk(pull_low === 1'b0 && rst_active === 1'b1, "R11 active in release wait",
        int'({pull_low, rst_active}), 1);
    pwr_fail = 1'b1;
    tick(1);
    chk(pull_low === 1'b1, "R10 power-fail overrides release wait", int'(pull_low), 1);
    tick(9);
    pwr_fail = 1'b0;
    wait_idle();
    tick(20);
    chk(rst_active === 1'b0, "R10 button sequence not resumed", int'(rst_active), 0);
    btn = 1'b0;
    tick(30);
    chk(exq.size() == 0 && pull_low === 1'b0, "R8 release after abort ignored",
        exq.size(), 0);

    finish_run();
  end
endmodule